// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Counting Timer

This block holds three independent 32-bit down-counters. Each channel has three registers: a live count, a reload constant and a control word. A shared run register gates the three channels. A channel takes its count tick from one of several sources. Five of these are power-of-four divisions of the block clock, all taken from one free-running 12-bit prescaler. One is an illegal code that falls back to divide-by-4096. The other two are tick inputs, one from a real-time clock and one from an external source. Both tick inputs are synchronised and edge-detected inside the block.

When a tick arrives and the count is zero, the channel reloads from its constant and sets a sticky underflow flag. The flag drives the channel's interrupt line when the channel's interrupt enable is set. Software can clear the flag but can never set it.

Registers are reached through a single-cycle synchronous write port and a combinational read port using byte addresses. The run register is at 0x00. The register group of channel n starts at 0x04 + 12·n, so the groups lie 12 bytes apart.

Top module: `tri_down_timer`

## Requirements
- R1: After reset, every count and constant register reads 0xFFFFFFFF, every control word reads 0, the run register reads 0 and all interrupt lines are low.
- R2: Bit n of the run register (address 0x00, bits [2:0]) lets channel n count. While the bit is 0 the channel's count holds its value; clearing the bit stops counting and setting it resumes counting.
- R3: Control bits [2:0] set to codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clock cycles. Ticks come from a shared prescaler that starts at 0 on reset and advances every cycle. A tick for a division of D falls on cycles where the prescaler value modulo D equals D−1.
- R4: Control code 5 ticks once every 4096 cycles. While code 5 is selected, control bit 9 reads 1; in every other case bit 9 reads 0, and writes do not affect it.
- R5: Code 6 counts rising edges of `rtc_tick_i` and code 7 counts rising edges of `ext_tick_i`, one step per edge. The count changes on the third rising clock edge after the input is first sampled high. An input held high counts only once.
- R6: Each tick of a running channel lowers a nonzero count by one. A tick that arrives while the count is zero loads the constant into the count and sets the underflow flag (control bit 8).
- R7: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag as it was and can never set it. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq_o[n]` is high exactly while channel n's underflow flag and its interrupt enable (control bit 5) are both 1.
- R9: A count write takes effect on the next cycle even while the channel runs, and counting continues from the written value. When a count write and a tick fall in the same cycle, the count takes the written value. If that tick was an underflow, the flag is still set.
- R10: Channel n's constant is at 0x04+12n, its count at 0x08+12n and its control word at 0x0C+12n. Control bits other than [2:0], 5, 8 and 9 read 0, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also drives the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick_i | input | 1 | Real-time tick source, asynchronous |
| ext_tick_i | input | 1 | External tick source, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Per-channel underflow interrupt |

## Verification
The channels run at the same time with different divisions and small constants, so that their underflows and reloads fall out of phase. Long runs at the illegal code show that the 4096-cycle period is independent of the 1024-cycle period. Edge-source phases pulse the tick inputs with short gaps and also hold them high, which separates edge counting from level counting and checks the synchronisation latency. Count writes every cycle at the moment of a tick, including zero written at underflow, plus flag-set attempts and clearing writes, show which source wins each same-cycle collision.

// File: rtl/tri_down_timer.sv
module tri_down_timer #(
  parameter int CW = 32,
  parameter int PW = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtc_tick_i,
  input  logic          ext_tick_i,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [2:0]    irq_o
);
  localparam int NCH = 3;
  localparam int STRIDE = 12;

  logic [PW-1:0]            pre_q;
  logic [NCH-1:0]           run_q, flag_q, en_q;
  logic [NCH-1:0][2:0]      sel_q;
  logic [NCH-1:0][CW-1:0]   cnt_q, cst_q;
  logic [2:0]               rtc_s, ext_s;
  logic [7:0]               div_tick;
  logic [NCH-1:0]           tick_ch, step, under, cnt_wr, cst_wr, ctl_wr;

  wire rtc_tick = rtc_s[1] & ~rtc_s[2];
  wire ext_tick = ext_s[1] & ~ext_s[2];
  wire run_wr   = bus_wr && bus_addr == '0;

  assign div_tick[7:6] = 2'b00;
  for (genvar k = 0; k < 6; k++) begin : g_div
    assign div_tick[k] = &pre_q[2*k+1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cst_wr[g]  = bus_wr && bus_addr == AW'(4 + STRIDE*g);
    assign cnt_wr[g]  = bus_wr && bus_addr == AW'(8 + STRIDE*g);
    assign ctl_wr[g]  = bus_wr && bus_addr == AW'(12 + STRIDE*g);
    assign tick_ch[g] = (sel_q[g] == 3'd6) ? rtc_tick :
                        (sel_q[g] == 3'd7) ? ext_tick : div_tick[sel_q[g]];
    assign step[g]    = run_q[g] & tick_ch[g];
    assign under[g]   = step[g] && cnt_q[g] == '0;
    assign irq_o[g]   = flag_q[g] & en_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rtc_s  <= '0;
      ext_s  <= '0;
      run_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
      cnt_q  <= '1;
      cst_q  <= '1;
    end else begin
      pre_q <= pre_q + 1'b1;
      rtc_s <= {rtc_s[1:0], rtc_tick_i};
      ext_s <= {ext_s[1:0], ext_tick_i};
      if (run_wr) run_q <= bus_wdata[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (cnt_wr[i])      cnt_q[i] <= bus_wdata;
        else if (under[i])  cnt_q[i] <= cst_q[i];
        else if (step[i])   cnt_q[i] <= cnt_q[i] - 1'b1;
        if (cst_wr[i]) cst_q[i] <= bus_wdata;
        if (ctl_wr[i]) begin
          sel_q[i] <= bus_wdata[2:0];
          en_q[i]  <= bus_wdata[5];
        end
        flag_q[i] <= under[i] | (ctl_wr[i] ? (flag_q[i] & bus_wdata[8]) : flag_q[i]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = {{(CW-NCH){1'b0}}, run_q};
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(4 + STRIDE*i)) bus_rdata = cst_q[i];
      if (bus_addr == AW'(8 + STRIDE*i)) bus_rdata = cnt_q[i];
      if (bus_addr == AW'(12 + STRIDE*i))
        bus_rdata = {{(CW-10){1'b0}}, sel_q[i] == 3'd5, flag_q[i], 2'b00, en_q[i], 2'b00, sel_q[i]};
    end
  end
endmodule

module tri_down_timer_chk #(
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          irq_o,
  input logic [2:0]          run_q,
  input logic [2:0]          tick_ch,
  input logic [2:0]          cnt_wr,
  input logic [2:0]          flag_q,
  input logic [2:0]          en_q,
  input logic [2:0][CW-1:0]  cnt_q,
  input logic [2:0][CW-1:0]  cst_q
);
  for (genvar i = 0; i < 3; i++) begin : g_a
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && tick_ch[i] && !cnt_wr[i] && cnt_q[i] != '0) |=> cnt_q[i] == CW'($past(cnt_q[i]) - 1'b1));
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && tick_ch[i] && !cnt_wr[i] && cnt_q[i] == '0) |=> cnt_q[i] == $past(cst_q[i]));
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !cnt_wr[i]) |=> $stable(cnt_q[i]));
    a_r7_flag_only_from_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(run_q[i] && tick_ch[i] && cnt_q[i] == '0));
    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[i]) |-> ($rose(flag_q[i]) || $rose(en_q[i])));
    a_r8_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flag_q[i]) || $fell(en_q[i])) |-> !irq_o[i]);
  end
endmodule

bind tri_down_timer tri_down_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .run_q(run_q), .tick_ch(tick_ch),
  .cnt_wr(cnt_wr), .flag_q(flag_q), .en_q(en_q), .cnt_q(cnt_q), .cst_q(cst_q)
);

// File: tb/tri_down_timer_tb_top.sv
`timescale 1ns/1ps
module tri_down_timer_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rtc_tick_i = 0, ext_tick_i = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tri_down_timer dut_i (.*);

  logic [31:0] m_cnt [3], m_cst [3];
  int          m_sel [3];
  bit          m_en [3], m_flag [3], m_run [3];
  int          m_pre;
  bit          r1, r2, r3, e1, e2, e3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 32'hFFFF_FFFF; m_cst[i] = 32'hFFFF_FFFF;
        m_sel[i] = 0; m_en[i] = 0; m_flag[i] = 0; m_run[i] = 0;
      end
      m_pre = 0; r1 = 0; r2 = 0; r3 = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      bit rt, et, tk, st, un;
      int d;
      rt = r2 && !r3; et = e2 && !e3;
      r3 = r2; r2 = r1; r1 = rtc_tick_i;
      e3 = e2; e2 = e1; e1 = ext_tick_i;
      for (int i = 0; i < 3; i++) begin
        if (m_sel[i] == 6) tk = rt;
        else if (m_sel[i] == 7) tk = et;
        else begin d = 1 << (2*m_sel[i] + 2); tk = (m_pre % d) == d - 1; end
        st = m_run[i] && tk;
        un = st && m_cnt[i] == 0;
        if (bus_wr && bus_addr == 8 + 12*i) m_cnt[i] = bus_wdata;
        else if (un) m_cnt[i] = m_cst[i];
        else if (st) m_cnt[i] = m_cnt[i] - 1;
        if (bus_wr && bus_addr == 4 + 12*i) m_cst[i] = bus_wdata;
        if (bus_wr && bus_addr == 12 + 12*i) begin
          if (!bus_wdata[8]) m_flag[i] = 0;
          m_sel[i] = int'(bus_wdata[2:0]);
          m_en[i] = bus_wdata[5];
        end
        if (un) m_flag[i] = 1;
      end
      if (bus_wr && bus_addr == 0)
        for (int i = 0; i < 3; i++) m_run[i] = bus_wdata[i];
      m_pre = (m_pre + 1) % 4096;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    mread = 0;
    if (a == 0) mread = {29'd0, m_run[2], m_run[1], m_run[0]};
    for (int i = 0; i < 3; i++) begin
      if (a == 4 + 12*i) mread = m_cst[i];
      if (a == 8 + 12*i) mread = m_cnt[i];
      if (a == 12 + 12*i)
        mread = {22'd0, m_sel[i] == 5, m_flag[i], 2'b00, m_en[i], 2'b00, 3'(m_sel[i])};
    end
  endfunction

  always @(negedge clk) if (rst_n && cmp_on) begin
    logic [2:0] ei;
    ei = {m_flag[2] && m_en[2], m_flag[1] && m_en[1], m_flag[0] && m_en[0]};
    n_cmp++;
    if (irq_o !== ei) begin
      n_bad++;
      $display("FAIL R8 (%s) irq_o actual=%b expected=%b t=%0t", tag, irq_o, ei, $time);
    end
    n_cmp++;
    if (bus_rdata !== mread(bus_addr)) begin
      n_bad++;
      $display("FAIL %s rdata@%0h actual=%h expected=%h t=%0t", tag, bus_addr, bus_rdata, mread(bus_addr), $time);
    end
  end

  int rot = 0;
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_wr = 0; bus_addr = 8'((rot % 13) * 4); rot++;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); #1;
    bus_wr = 0; bus_addr = a; #0.5;
    n_cmp++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s read@%0h actual=%h expected=%h", t, a, bus_rdata, e);
    end
  endtask

  task automatic pulse(input bit which, input int hi, input int gap);
    @(negedge clk); #1;
    if (which) ext_tick_i = 1; else rtc_tick_i = 1;
    idle(hi);
    if (which) ext_tick_i = 0; else rtc_tick_i = 0;
    idle(gap);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state, expected from the requirement
    for (int i = 0; i < 3; i++) begin
      chk_rd(8'(4 + 12*i), 32'hFFFF_FFFF, "R1");
      chk_rd(8'(8 + 12*i), 32'hFFFF_FFFF, "R1");
      chk_rd(8'(12 + 12*i), 32'h0, "R1");
    end
    chk_rd(8'h00, 32'h0, "R1");
    n_cmp++;
    if (irq_o !== 3'b000) begin n_bad++; $display("FAIL R1 irq actual=%b expected=000", irq_o); end
    cmp_on = 1;

    tag = "R3";
    wr(8'h04, 5);  wr(8'h08, 5);  wr(8'h0C, 32'h20);
    wr(8'h10, 3);  wr(8'h14, 3);  wr(8'h18, 32'h21);
    wr(8'h1C, 2);  wr(8'h20, 2);  wr(8'h24, 32'h22);
    wr(8'h00, 7);
    idle(400);
    wr(8'h18, 32'h23); wr(8'h14, 1);
    idle(1200);

    tag = "R6";
    wr(8'h04, 0); wr(8'h08, 2);
    idle(60);

    tag = "R7";
    wr(8'h0C, 32'h20);
    chk_rd(8'h0C, mread(8'h0C), "R7");
    idle(3);
    wr(8'h18, 32'h23);
    wr(8'h18, 32'h123);
    chk_rd(8'h18, mread(8'h18), "R7");
    idle(40);
    wr(8'h0C, 32'h120); wr(8'h0C, 32'h120);
    idle(20);

    tag = "R8";
    wr(8'h0C, 32'h100);
    idle(10);
    wr(8'h0C, 32'h120);
    idle(10);
    wr(8'h0C, 32'h020);
    idle(10);

    tag = "R10";
    for (int a = 0; a < 64; a++) chk_rd(8'(a * 4), mread(8'(a * 4)), "R10");
    wr(8'h0C, 32'hFFFF_FE20);
    idle(30);

    tag = "R4";
    wr(8'h1C, 0); wr(8'h20, 1); wr(8'h24, 32'h25);
    idle(9000);
    wr(8'h24, 32'h24);
    idle(300);

    tag = "R5";
    wr(8'h10, 2); wr(8'h14, 2); wr(8'h18, 32'h26);
    wr(8'h1C, 1); wr(8'h20, 3); wr(8'h24, 32'h27);
    for (int p = 0; p < 6; p++) begin
      pulse(0, 1, 2 + p);
      pulse(1, 2, 3);
    end
    pulse(0, 40, 10);
    pulse(1, 50, 10);
    @(negedge clk); #1; rtc_tick_i = 1; ext_tick_i = 1;
    idle(8);
    rtc_tick_i = 0; ext_tick_i = 0;
    idle(8);

    tag = "R9";
    wr(8'h04, 3); wr(8'h0C, 32'h20);
    wr(8'h08, 10);
    idle(12);
    wr(8'h08, 7);
    idle(9);
    for (int k = 0; k < 48; k++) begin
      @(negedge clk); #1;
      bus_wr = 1; bus_addr = 8'h08; bus_wdata = (k % 3 == 0) ? 0 : k;
    end
    @(negedge clk); #1; bus_wr = 0;
    wr(8'h0C, 32'h20);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      bus_wr = 1; bus_addr = 8'h08; bus_wdata = 0;
    end
    @(negedge clk); #1; bus_wr = 0;
    idle(30);

    tag = "R2";
    wr(8'h00, 0);
    idle(300);
    wr(8'h00, 5);
    idle(200);
    wr(8'h00, 2);
    pulse(0, 1, 4);
    wr(8'h00, 7);
    idle(100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule